// File: doc/BRIEF.md
# I2C GPIO Expander (two 8-bit ports)

This block is an I2C target that gives a host sixteen general-purpose I/O lines, grouped into two 8-bit ports. Each port has four byte-wide registers: a sampled input register, an output data register, a polarity mask and a direction register. A host addresses the block, writes a command byte that selects a register, and then writes or reads data bytes. The register pointer steps between the two ports of the selected register kind on each data byte. When a pin set as an input no longer matches the value last latched for it, an active-low interrupt line goes low.

SCL and SDA enter through two-flop synchronisers and are handled at byte level by an oversampling state machine in the system clock domain. The open-drain SDA is modelled as a pull-down enable. The pin side is a plain level interface: one input vector, one output data vector and one output-enable vector. None of the block's interfaces is a valid/ready stream. The host is the only source of pacing, and the target never stretches SCL, so the block applies no back-pressure. The interrupt is a plain level, where 0 means the line is pulled low.

Top module: `gpx_expander`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), the output registers hold 8'hFF, the polarity registers hold 8'h00, the direction registers hold 8'hFF and the latched input registers hold 8'h00.
- R2: The target answers only the 7-bit address formed from 4'b0100 followed by `addr_sel[2:0]`. On any other address it does not pull SDA low and leaves every register unchanged.
- R3: The command byte's three low bits select the register. Values 0 and 1 select input, 2 and 3 select output, 4 and 5 select polarity, and 6 and 7 select direction. An even value selects port 0 (pins 7:0) and an odd value selects port 1 (pins 15:8).
- R4: After each data byte written or read, the port bit of the pointer toggles and the register kind stays the same. A read with no command byte continues from the pointer's current value.
- R5: A data byte written to an output, polarity or direction register is stored. A data byte written to an input register changes nothing.
- R6: A direction bit of 1 makes its pin an input (`pin_oe` = 0). A direction bit of 0 makes the pin an output (`pin_oe` = 1). `pin_out` always shows the output registers.
- R7: Reading an input register returns the synchronised pin levels XOR the polarity register for that port, and latches the raw pin levels into that port's input register.
- R8: Reading an output, polarity or direction register returns its stored value.
- R9: `irq_n` is 0 exactly when some pin with direction bit 1 differs from its latched input bit. Pins set as outputs and the polarity mask have no effect on it.
- R10: A START, including a repeated START, restarts address reception. A STOP returns the target to idle at any bit position, and a partly received byte is discarded. A host NACK ends a read.
- R11: The target pulls SDA low during the ninth clock after a matching address byte, after a command byte and after each written data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Resolved bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 3 | Low three address bits |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Output data for the pins |
| pin_oe | output | 16 | 1 drives the pin from pin_out |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
The assertions check several rules on every cycle. A START always leads to address reception and a STOP always releases SDA. SDA stays low for the whole acknowledge phase and is never driven while the target is idle. A write to an input register leaves the latched values unchanged. Direction registers change only on a write strobe. The pointer steps after every data byte, and a read of an input register latches exactly the synchronised pins. Only the bench's bus scenarios can show the end-to-end behaviour: the address match against `addr_sel`, the byte values returned through the polarity mask, the interrupt rising and falling as pins change and as the host reads, and the discarding of a byte cut short by a STOP.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } slv_state_t;

  typedef enum logic [1:0] {
    K_IN  = 2'd0,
    K_OUT = 2'd1,
    K_POL = 2'd2,
    K_CFG = 2'd3
  } reg_kind_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_BIT}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_i2c_slave.sv
module gpx_i2c_slave
  import gpx_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic [2:0]        addr_sel,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_drv,
  output logic              cmd_stb,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  slv_state_t        state, ret_state;
  logic              scl_q, sda_q, mack;
  logic [BYTE_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              scl_rise, scl_fall, start_evt, stop_evt, byte_done, addr_hit;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;
  assign byte_done = scl_fall && (cnt == CNT_FULL);
  assign addr_hit  = (sr[BYTE_W-1:1] == {ADDR_HI, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      sr        <= '0;
      cnt       <= '0;
      mack      <= 1'b0;
      sda_drv   <= 1'b0;
      cmd_stb   <= 1'b0;
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
      wr_byte   <= '0;
    end else begin
      scl_q   <= scl;
      sda_q   <= sda;
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      if (start_evt) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        sda_drv <= 1'b0;
      end else if (stop_evt) begin
        state   <= ST_IDLE;
        sda_drv <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && cnt != CNT_FULL) begin
              sr  <= {sr[BYTE_W-2:0], sda};
              cnt <= cnt + CNT_ONE;
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_drv   <= 1'b1;
                  state     <= ST_ACK;
                  ret_state <= sr[0] ? ST_TX : ST_CMD;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_drv   <= 1'b1;
                state     <= ST_ACK;
                ret_state <= ST_WDATA;
                wr_byte   <= sr;
                if (state == ST_CMD) cmd_stb <= 1'b1;
                else                 wr_stb  <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= ret_state;
              if (ret_state == ST_TX) begin
                sda_drv <= ~rd_byte[BYTE_W-1];
                sr      <= {rd_byte[BYTE_W-2:0], 1'b0};
                cnt     <= CNT_ONE;
                rd_stb  <= 1'b1;
              end else begin
                sda_drv <= 1'b0;
                cnt     <= '0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_drv <= 1'b0;
                mack    <= 1'b0;
                state   <= ST_TXACK;
              end else begin
                sda_drv <= ~sr[BYTE_W-1];
                sr      <= {sr[BYTE_W-2:0], 1'b0};
                cnt     <= cnt + CNT_ONE;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack <= ~sda;
            end else if (scl_fall) begin
              if (mack) begin
                sda_drv <= ~rd_byte[BYTE_W-1];
                sr      <= {rd_byte[BYTE_W-2:0], 1'b0};
                cnt     <= CNT_ONE;
                rd_stb  <= 1'b1;
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: a START always reopens address reception
  p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> state == ST_ADDR);

  // R10: a STOP always idles the target with SDA released
  p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_drv);

  // R11: SDA is held low for the whole acknowledge phase
  p_ack_holds_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ACK |-> sda_drv);

  // R2: an idle target never pulls the bus
  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_drv);
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int PORTS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_stb,
  input  logic                    wr_stb,
  input  logic                    rd_stb,
  input  logic [BYTE_W-1:0]       wr_byte,
  input  logic [PORTS*BYTE_W-1:0] pins_s,
  output logic [BYTE_W-1:0]       rd_byte,
  output logic [PORTS*BYTE_W-1:0] pin_out,
  output logic [PORTS*BYTE_W-1:0] pin_oe,
  output logic                    irq_n
);
  localparam int PW = $clog2(PORTS);
  localparam int NP = PORTS * BYTE_W;

  logic [NP-1:0] out_q, pol_q, cfg_q, in_q;
  reg_kind_t     kind;
  logic [PW-1:0] port;
  logic [PORTS-1:0] diff;
  int            base;

  assign base = int'(port) * BYTE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
      in_q  <= '0;
      kind  <= K_IN;
      port  <= '0;
    end else begin
      if (cmd_stb) begin
        kind <= reg_kind_t'(wr_byte[PW+1:PW]);
        port <= wr_byte[PW-1:0];
      end else if (wr_stb || rd_stb) begin
        port <= port + 1'b1;
      end
      if (wr_stb) begin
        unique case (kind)
          K_OUT:   out_q[base +: BYTE_W] <= wr_byte;
          K_POL:   pol_q[base +: BYTE_W] <= wr_byte;
          K_CFG:   cfg_q[base +: BYTE_W] <= wr_byte;
          default: ;
        endcase
      end
      if (rd_stb && kind == K_IN) in_q[base +: BYTE_W] <= pins_s[base +: BYTE_W];
    end
  end

  always_comb begin
    unique case (kind)
      K_IN:    rd_byte = pins_s[base +: BYTE_W] ^ pol_q[base +: BYTE_W];
      K_OUT:   rd_byte = out_q[base +: BYTE_W];
      K_POL:   rd_byte = pol_q[base +: BYTE_W];
      default: rd_byte = cfg_q[base +: BYTE_W];
    endcase
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign diff[p] = |(cfg_q[p*BYTE_W +: BYTE_W] &
                       (pins_s[p*BYTE_W +: BYTE_W] ^ in_q[p*BYTE_W +: BYTE_W]));

    // R7: an input read latches exactly the synchronised pins of that port
    p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && kind == K_IN && port == PW'(p)) |=>
        in_q[p*BYTE_W +: BYTE_W] == $past(pins_s[p*BYTE_W +: BYTE_W]));
  end

  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;
  assign irq_n   = ~|diff;

  // R4: each data byte steps the pointer to the other port
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_stb || rd_stb) && !cmd_stb) |=> port == PW'($past(port) + 1'b1));

  // R5: writes aimed at an input register leave it untouched
  p_in_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && kind == K_IN) |=> $stable(in_q));

  // R5: direction changes only through a write strobe
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg_q));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int         PORTS   = 2,
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic [2:0]              addr_sel,
  input  logic [PORTS*BYTE_W-1:0] pin_in,
  output logic [PORTS*BYTE_W-1:0] pin_out,
  output logic [PORTS*BYTE_W-1:0] pin_oe,
  output logic                    irq_n
);
  localparam int NP = PORTS * BYTE_W;

  logic [1:0]        bus_s;
  logic [NP-1:0]     pins_s;
  logic              cmd_stb, wr_stb, rd_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  gpx_sync #(.W(2), .STAGES(2), .RST_BIT(1'b1)) u_bus_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({scl_i, sda_i}),
    .q (bus_s)
  );

  gpx_sync #(.W(NP), .STAGES(2), .RST_BIT(1'b0)) u_pin_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (pins_s)
  );

  gpx_i2c_slave #(.ADDR_HI(ADDR_HI)) u_slave (
    .clk (clk),
    .rst_n (rst_n),
    .scl (bus_s[1]),
    .sda (bus_s[0]),
    .addr_sel (addr_sel),
    .rd_byte (rd_byte),
    .sda_drv (sda_oe),
    .cmd_stb (cmd_stb),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .wr_byte (wr_byte)
  );

  gpx_regfile #(.PORTS(PORTS)) u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .cmd_stb (cmd_stb),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .wr_byte (wr_byte),
    .pins_s (pins_s),
    .rd_byte (rd_byte),
    .pin_out (pin_out),
    .pin_oe (pin_oe),
    .irq_n (irq_n)
  );
endmodule

// File: tb/gpx_expander_tb_top.sv
module gpx_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0]  asel = 3'd0;
  logic [15:0] pins = 16'h0000;
  wire         sda_oe, irq_n;
  wire  [15:0] pin_out, pin_oe;
  wire         sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  gpx_expander dut_i (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
    .sda_oe (sda_oe), .addr_sel (asel), .pin_in (pins),
    .pin_out (pin_out), .pin_oe (pin_oe), .irq_n (irq_n)
  );

  int   vectors = 0, errs = 0;
  bit   chk_en = 1'b0, done = 1'b0;
  logic [7:0] m_out [2], m_pol [2], m_cfg [2], m_in [2];
  int   m_kind = 0, m_port = 0;
  logic [7:0] rdv [4];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference compared on every settled clock
  always @(negedge clk) begin
    if (chk_en && !done) begin
      check("R6 pin_oe", {16'h0, pin_oe}, {16'h0, ~m_cfg[1], ~m_cfg[0]});
      check("R6 pin_out", {16'h0, pin_out}, {16'h0, m_out[1], m_out[0]});
      check("R9 irq_n", {31'h0, irq_n},
            {31'h0, ~|({m_cfg[1], m_cfg[0]} & (pins ^ {m_in[1], m_in[0]}))});
    end
  end

  task automatic qw(); repeat (8) @(negedge clk); endtask
  task automatic settle(); repeat (4) @(negedge clk); chk_en = 1'b1; endtask

  task automatic m_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic m_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic wbit(bit b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask
  task automatic rbit(output bit b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic wbyte(logic [7:0] v, output bit nak);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(nak);
  endtask
  task automatic rbyte(bit last, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(last);
  endtask

  task automatic model_cmd(logic [7:0] c);
    m_kind = int'(c[2:1]);
    m_port = int'(c[0]);
  endtask
  task automatic model_write(logic [7:0] d);
    case (m_kind)
      1: m_out[m_port] = d;
      2: m_pol[m_port] = d;
      3: m_cfg[m_port] = d;
      default: ;
    endcase
    m_port ^= 1;
  endtask
  function automatic logic [7:0] model_read();
    logic [7:0] e;
    case (m_kind)
      0: begin e = pins[m_port*8 +: 8] ^ m_pol[m_port]; m_in[m_port] = pins[m_port*8 +: 8]; end
      1: e = m_out[m_port];
      2: e = m_pol[m_port];
      default: e = m_cfg[m_port];
    endcase
    m_port ^= 1;
    return e;
  endfunction

  task automatic do_write(logic [2:0] a, logic [7:0] cmd, int n,
                          logic [7:0] d0, logic [7:0] d1, logic [7:0] d2, bit hit);
    bit nak;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    chk_en = 1'b0;
    m_start();
    wbyte({4'b0100, a, 1'b0}, nak);
    if (!hit) begin
      check("R2 nack on foreign address", {31'h0, nak}, 32'h1);
      m_stop(); settle(); return;
    end
    check("R11 address ack", {31'h0, nak}, 32'h0);
    wbyte(cmd, nak);
    check("R11 command ack", {31'h0, nak}, 32'h0);
    model_cmd(cmd);
    for (int i = 0; i < n; i++) begin
      wbyte(d[i], nak);
      check("R11 data ack", {31'h0, nak}, 32'h0);
      model_write(d[i]);
    end
    m_stop(); settle();
  endtask

  task automatic do_read(logic [2:0] a, logic [7:0] cmd, bit use_cmd, int n, string req);
    bit nak;
    logic [7:0] e;
    chk_en = 1'b0;
    m_start();
    if (use_cmd) begin
      wbyte({4'b0100, a, 1'b0}, nak);
      check("R11 address ack", {31'h0, nak}, 32'h0);
      wbyte(cmd, nak);
      check("R11 command ack", {31'h0, nak}, 32'h0);
      model_cmd(cmd);
      m_start();  // repeated START, R10
    end
    wbyte({4'b0100, a, 1'b1}, nak);
    check("R10 read address ack", {31'h0, nak}, 32'h0);
    for (int i = 0; i < n; i++) begin
      e = model_read();
      rbyte(i == n - 1, rdv[i]);
      check(req, {24'h0, rdv[i]}, {24'h0, e});
    end
    m_stop(); settle();
  endtask

  task automatic set_pins(logic [15:0] v);
    chk_en = 1'b0; pins = v; settle();
  endtask

  initial begin
    bit nak;
    for (int p = 0; p < 2; p++) begin
      m_out[p] = 8'hFF; m_pol[p] = 8'h00; m_cfg[p] = 8'hFF; m_in[p] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state at the ports
    check("R1 pin_oe after reset", {16'h0, pin_oe}, 32'h0);
    check("R1 pin_out after reset", {16'h0, pin_out}, 32'hFFFF);
    check("R1 irq_n after reset", {31'h0, irq_n}, 32'h1);
    do_read(3'd0, 8'd2, 1'b1, 2, "R8 output readback");
    check("R1 output default", {rdv[0], rdv[1]}, 16'hFFFF);
    do_read(3'd0, 8'd4, 1'b1, 2, "R8 polarity readback");
    check("R1 polarity default", {rdv[0], rdv[1]}, 16'h0000);
    do_read(3'd0, 8'd6, 1'b1, 2, "R8 direction readback");
    check("R1 direction default", {rdv[0], rdv[1]}, 16'hFFFF);
    // R3 / R5 / R6 direction and output data
    do_write(3'd0, 8'd6, 2, 8'h0F, 8'hF0, 8'h00, 1'b1);
    do_write(3'd0, 8'd2, 2, 8'hA5, 8'h3C, 8'h00, 1'b1);
    check("R6 pin_oe from direction", {16'h0, pin_oe}, 32'h0FF0);
    check("R6 pin_out from output", {16'h0, pin_out}, 32'h3CA5);
    do_read(3'd0, 8'd6, 1'b1, 2, "R8 direction readback");
    check("R3 direction pair", {rdv[0], rdv[1]}, 16'h0FF0);
    // R4 pointer toggles across three bytes starting at port 1
    do_write(3'd0, 8'd3, 3, 8'h11, 8'h22, 8'h33, 1'b1);
    check("R4 toggled writes", {16'h0, pin_out}, 32'h3322);
    // R9 interrupt from input pins only
    set_pins(16'h00F0);
    check("R9 output pins ignored", {31'h0, irq_n}, 32'h1);
    set_pins(16'h0003);
    check("R9 input change asserts", {31'h0, irq_n}, 32'h0);
    do_read(3'd0, 8'd0, 1'b1, 1, "R7 input read");
    check("R7 port0 value", {24'h0, rdv[0]}, 32'h03);
    check("R7 read clears irq", {31'h0, irq_n}, 32'h1);
    // R5 write to input register ignored
    set_pins(16'h8003);
    check("R9 port1 change asserts", {31'h0, irq_n}, 32'h0);
    do_write(3'd0, 8'd1, 1, 8'h80, 8'h00, 8'h00, 1'b1);
    check("R5 input write ignored", {31'h0, irq_n}, 32'h0);
    do_read(3'd0, 8'd1, 1'b1, 1, "R7 input read");
    check("R7 port1 read clears irq", {31'h0, irq_n}, 32'h1);
    // R7 polarity mask
    do_write(3'd0, 8'd4, 2, 8'hFF, 8'h0F, 8'h00, 1'b1);
    check("R9 polarity has no irq effect", {31'h0, irq_n}, 32'h1);
    do_read(3'd0, 8'd0, 1'b1, 2, "R7 inverted input read");
    check("R7 inverted port0", {24'h0, rdv[0]}, 32'hFC);
    check("R7 inverted port1", {24'h0, rdv[1]}, 32'h8F);
    // R4 read without command continues from pointer (port 0 input)
    do_read(3'd0, 8'd0, 1'b0, 1, "R4 pointer continue");
    check("R4 continued value", {24'h0, rdv[0]}, 32'hFC);
    // R10 STOP in mid byte discards it
    chk_en = 1'b0;
    m_start();
    wbyte({4'b0100, 3'd0, 1'b0}, nak);
    wbyte(8'd2, nak);
    model_cmd(8'd2);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    m_stop(); settle();
    check("R10 partial byte dropped", {16'h0, pin_out}, 32'h3322);
    // R2 address selection
    do_write(3'd1, 8'd6, 1, 8'h00, 8'h00, 8'h00, 1'b0);
    check("R2 foreign write ignored", {16'h0, pin_oe}, 32'h0FF0);
    chk_en = 1'b0; asel = 3'd5; settle();
    do_write(3'd5, 8'd6, 1, 8'h00, 8'h00, 8'h00, 1'b1);
    check("R2 new address accepted", {16'h0, pin_oe}, 32'h0FFF);
    do_write(3'd0, 8'd6, 1, 8'hFF, 8'h00, 8'h00, 1'b0);
    check("R2 old address rejected", {16'h0, pin_oe}, 32'h0FFF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule